// File: doc/BRIEF.md
# Video Port Wait-State Stretcher

This block holds the CPU in a video-port I/O cycle until a slow video display processor has had time to finish its memory access. Software then needs no padding delays between port accesses. It gates an already decoded video-port select with the CPU I/O request and read/write strobes. When it sees a qualifying access, it pulls the active-low CPU WAIT line low at once, through a combinational path, so that the CPU samples it in time.

The hold time is counted in ticks of a fixed timing clock (8 MHz in the target system) that is independent of the CPU clock. The time held is therefore the same whatever rate the CPU runs at, up to 16 MHz. The access is carried into the timing domain through a two-flop synchroniser. The end-of-hold flag is carried back into the CPU domain the same way, so WAIT is released in step with the CPU clock. At CPU rates of 8 MHz or below, the video chip's own wait function is enough. An enable input then keeps this block from ever driving WAIT.

Top module: `vidwait_top`

## Requirements
- R1: An access is qualified when `vid_port_sel` is 1, `ioreq_n` is 0 and at least one of `rd_n`/`wr_n` is 0. With `wait_en` high and `rst` low, a qualified access drives `cpu_wait_n` to 0 combinationally, in the same instant, for both reads and writes.
- R2: When the access is not qualified, `cpu_wait_n` stays 1. This covers a select with `ioreq_n` high (memory cycle) and a select with both `rd_n` and `wr_n` high.
- R3: Once asserted for a qualified access held steady, `cpu_wait_n` stays 0 for at least `HOLD_TICKS` timing-clock periods. It returns to 1 no later than `HOLD_TICKS`+3 timing-clock periods plus 3 CPU clock periods after the access began.
- R4: One access produces exactly one hold. After release, `cpu_wait_n` stays 1 for as long as the same access remains qualified.
- R5: The block re-arms once the access has been unqualified for at least 4 timing-clock periods plus 3 CPU clock periods. The next qualified access then drives `cpu_wait_n` to 0 again.
- R6: While `wait_en` is 0 (held steady for the whole access), `cpu_wait_n` stays 1 and no hold is started.
- R7: While the synchronous active-high `rst` is 1, `cpu_wait_n` is 1 and the hold state is cleared. After reset, an access that is still qualified starts a fresh hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU clock, up to 16 MHz |
| tick_clk | input | 1 | Fixed timing clock used to measure the hold |
| rst | input | 1 | Synchronous active-high reset, held for several periods of both clocks |
| wait_en | input | 1 | 1 lets the block insert waits; 0 for low-speed CPU modes |
| vid_port_sel | input | 1 | Decoded video I/O port select, active high |
| ioreq_n | input | 1 | CPU I/O request, active low |
| rd_n | input | 1 | CPU read strobe, active low |
| wr_n | input | 1 | CPU write strobe, active low |
| cpu_wait_n | output | 1 | CPU WAIT line, active low |

## Verification
Suppose the release flag in the timing domain is stuck or set too early. The next access either releases WAIT within a tick or two, which breaks the lower bound of R3. Or it never asserts WAIT at all, which shows at once on the R1 sample. A counter that fails to stop holds WAIT past the R3 upper bound, within about ten timing ticks. A flag that never clears leaves the following access without a wait, so the R5 check exposes it on the very next access. A start condition that ignores the enable shows as WAIT going low during the R6 window.

// File: rtl/vidwait_pkg.sv
package vidwait_pkg;

  // Counter width for a hold of n ticks (never below one bit).
  function automatic int hold_cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // True on the last tick of a hold of n ticks, counting from zero.
  function automatic logic hold_is_last(input int unsigned cnt, input int n);
    return cnt == n - 1;
  endfunction

endpackage

// File: rtl/vidwait_decode.sv
module vidwait_decode (
  input  logic vid_port_sel,
  input  logic ioreq_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic access
);

  logic io_cycle;
  logic strobe_on;

  assign io_cycle  = ~ioreq_n;
  assign strobe_on = ~rd_n | ~wr_n;
  assign access    = vid_port_sel & io_cycle & strobe_on;

endmodule

// File: rtl/vidwait_sync.sv
module vidwait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= 1'b0;
      else     chain[i] <= chain[i-1];
    end

    AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (rst)
      chain[i] == $past(chain[i-1])); // R3
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/vidwait_timer.sv
module vidwait_timer
  import vidwait_pkg::*;
#(
  parameter int HOLD_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic acc_sync,
  output logic running,
  output logic released
);

  localparam int CW = hold_cnt_width(HOLD_TICKS);

  logic [CW-1:0] cnt;
  logic          start_ev;
  logic          done_ev;
  logic          rearm_ev;

  assign start_ev = !running && !released && acc_sync && en;
  assign done_ev  = running && hold_is_last(32'(cnt), HOLD_TICKS);
  assign rearm_ev = released && !acc_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      running  <= 1'b0;
      released <= 1'b0;
    end else if (running) begin
      if (done_ev) begin
        cnt      <= '0;
        running  <= 1'b0;
        released <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (start_ev) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (rearm_ev) begin
      released <= 1'b0;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    running |-> (32'(cnt) < HOLD_TICKS)); // R3
  AST_START_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!running && !released && acc_sync && en) |=> running); // R3
  AST_RELEASE_FROM_COUNT: assert property (@(posedge clk) disable iff (rst)
    $rose(released) |-> $past(running)); // R3
  AST_ONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(running && released)); // R4
  AST_REARM: assert property (@(posedge clk) disable iff (rst)
    (released && !acc_sync) |=> !released); // R5
  AST_EN_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (!en && !running) |=> !running); // R6

endmodule

// File: rtl/vidwait_top.sv
module vidwait_top #(
  parameter int HOLD_TICKS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic cpu_clk,
  input  logic tick_clk,
  input  logic rst,
  input  logic wait_en,
  input  logic vid_port_sel,
  input  logic ioreq_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic cpu_wait_n
);

  logic access;
  logic acc_tick;
  logic hold_running;
  logic hold_released;
  logic release_cpu;
  logic wait_req;

  vidwait_decode u_decode (
    .vid_port_sel (vid_port_sel),
    .ioreq_n      (ioreq_n),
    .rd_n         (rd_n),
    .wr_n         (wr_n),
    .access       (access)
  );

  vidwait_sync #(.STAGES(SYNC_STAGES)) u_sync_acc (
    .clk (tick_clk),
    .rst (rst),
    .d   (access),
    .q   (acc_tick)
  );

  vidwait_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
    .clk      (tick_clk),
    .rst      (rst),
    .en       (wait_en),
    .acc_sync (acc_tick),
    .running  (hold_running),
    .released (hold_released)
  );

  vidwait_sync #(.STAGES(SYNC_STAGES)) u_sync_rel (
    .clk (cpu_clk),
    .rst (rst),
    .d   (hold_released),
    .q   (release_cpu)
  );

  // Single release term: WAIT falls only with the access or the synced flag.
  assign wait_req   = wait_en & access & ~release_cpu & ~rst;
  assign cpu_wait_n = ~wait_req;

  AST_RELEASE_NEEDS_FLAG: assert property (@(posedge cpu_clk) disable iff (rst)
    (access && wait_en && $rose(cpu_wait_n)) |-> release_cpu); // R3

endmodule

// File: tb/vidwait_top_tb.sv
`timescale 1ns/100ps
module vidwait_top_tb;

  localparam int  HOLD    = 4;
  localparam real T_CPU   = 5.0;
  localparam real T_TICK  = 20.0;
  localparam int  MIN_NS  = HOLD * 20;
  localparam int  MAX_NS  = (HOLD + 3) * 20 + 3 * 5;

  logic cpu_clk = 1'b0;
  logic tick_clk = 1'b0;
  logic rst = 1'b1;
  logic wait_en = 1'b1;
  logic vid_port_sel = 1'b0;
  logic ioreq_n = 1'b1;
  logic rd_n = 1'b1;
  logic wr_n = 1'b1;
  logic cpu_wait_n;

  int total = 0;
  int bad = 0;

  always #(T_CPU / 2.0) cpu_clk = ~cpu_clk;
  always #(T_TICK / 2.0) tick_clk = ~tick_clk;

  vidwait_top #(.HOLD_TICKS(HOLD)) u_dut (
    .cpu_clk      (cpu_clk),
    .tick_clk     (tick_clk),
    .rst          (rst),
    .wait_en      (wait_en),
    .vid_port_sel (vid_port_sel),
    .ioreq_n      (ioreq_n),
    .rd_n         (rd_n),
    .wr_n         (wr_n),
    .cpu_wait_n   (cpu_wait_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic io_on(input bit is_wr);
    vid_port_sel = 1'b1;
    ioreq_n = 1'b0;
    if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
  endtask

  task automatic io_off();
    vid_port_sel = 1'b0;
    ioreq_n = 1'b1;
    rd_n = 1'b1;
    wr_n = 1'b1;
  endtask

  // Measure how long WAIT stays low, in ns, polling every 1 ns.
  task automatic low_time(output int ns);
    ns = 0;
    while (!cpu_wait_n && ns < 1000) begin
      #1;
      ns++;
    end
  endtask

  task automatic settle();
    io_off();
    #200;
  endtask

  task automatic t_reset();
    check(cpu_wait_n === 1'b1, "R7 wait high in reset", int'(cpu_wait_n), 1);
    @(posedge tick_clk); #2;
    rst = 1'b0;
    #50;
    check(cpu_wait_n === 1'b1, "R7 idle after reset", int'(cpu_wait_n), 1);
  endtask

  task automatic t_hold(input bit is_wr, input string tag);
    int ns;
    @(posedge tick_clk); #2;
    io_on(is_wr);
    #0.5;
    check(cpu_wait_n === 1'b0, {tag, " immediate wait"}, int'(cpu_wait_n), 0);
    low_time(ns);
    check(ns >= MIN_NS && ns <= MAX_NS, "R3 hold length ns", ns, MIN_NS);
    settle();
  endtask

  task automatic t_hold_late_phase();
    int ns;
    @(posedge tick_clk); #9;
    io_on(1'b0);
    #0.5;
    low_time(ns);
    check(ns >= MIN_NS && ns <= MAX_NS, "R3 hold length other phase", ns, MIN_NS);
    settle();
  endtask

  task automatic t_long_access();
    int ns;
    int highs = 0;
    io_on(1'b0);
    #0.5;
    low_time(ns);
    for (int i = 0; i < 80; i++) begin
      #5;
      if (cpu_wait_n === 1'b1) highs++;
    end
    check(highs == 80, "R4 single hold on long access", highs, 80);
    io_off();
    #110;
    io_on(1'b1);
    #0.5;
    check(cpu_wait_n === 1'b0, "R5 re-armed after idle", int'(cpu_wait_n), 0);
    low_time(ns);
    check(ns >= MIN_NS && ns <= MAX_NS, "R5 second hold length", ns, MIN_NS);
    settle();
  endtask

  task automatic t_unqualified();
    int lows = 0;
    vid_port_sel = 1'b1; ioreq_n = 1'b1; rd_n = 1'b0;
    for (int i = 0; i < 40; i++) begin #5; if (cpu_wait_n !== 1'b1) lows++; end
    check(lows == 0, "R2 memory cycle no wait", lows, 0);
    io_off();
    vid_port_sel = 1'b1; ioreq_n = 1'b0;
    for (int i = 0; i < 40; i++) begin #5; if (cpu_wait_n !== 1'b1) lows++; end
    check(lows == 0, "R2 no strobe no wait", lows, 0);
    io_off();
    vid_port_sel = 1'b0; ioreq_n = 1'b0; wr_n = 1'b0;
    for (int i = 0; i < 40; i++) begin #5; if (cpu_wait_n !== 1'b1) lows++; end
    check(lows == 0, "R2 other port no wait", lows, 0);
    settle();
  endtask

  task automatic t_disabled();
    int lows = 0;
    wait_en = 1'b0;
    #50;
    io_on(1'b1);
    for (int i = 0; i < 80; i++) begin #5; if (cpu_wait_n !== 1'b1) lows++; end
    check(lows == 0, "R6 disabled never waits", lows, 0);
    settle();
    wait_en = 1'b1;
    #50;
    t_hold(1'b0, "R6 re-enabled");
  endtask

  task automatic t_reset_mid();
    int ns;
    io_on(1'b0);
    #30;
    @(posedge tick_clk); #2;
    rst = 1'b1;
    #0.5;
    check(cpu_wait_n === 1'b1, "R7 reset releases wait", int'(cpu_wait_n), 1);
    #60;
    rst = 1'b0;
    #0.5;
    check(cpu_wait_n === 1'b0, "R7 fresh hold after reset", int'(cpu_wait_n), 0);
    low_time(ns);
    check(ns >= MIN_NS && ns <= MAX_NS, "R7 fresh hold length", ns, MIN_NS);
    settle();
  endtask

  initial begin
    #500000;
    check(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #33;
    t_reset();
    t_hold(1'b0, "R1 read");
    t_hold(1'b1, "R1 write");
    t_hold_late_phase();
    t_long_access();
    t_unqualified();
    t_disabled();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule